// File: doc/BRIEF.md
# Byte/Word Data Memory Access Unit

This unit sits between a 16-bit processor core and a data memory made of two byte-wide lanes. The two lanes share one word-address decoder and each has its own write strobe. The core presents one load or store per cycle. A request carries an effective address, a flag that selects a byte or a word access, the store data, and the current high byte of the destination register.

For a store, the unit drives the lane write enables. For a load, one cycle later it returns the value to be written back to the destination register. A byte load places the selected byte in the low byte of that value and keeps the old high byte of the register.

A word access at an odd address raises a one-cycle address-error pulse, and the faulting address is captured with it. A faulty word load still delivers its data. A faulty word store writes nothing.

The unit also gives the post-incremented pointer value for the current access size. It has a separate helper that sign-extends or zero-extends a 16-bit value from its low byte.

Top module: `dmem_access_unit`

## Requirements
- R1: After reset, rd_valid and addr_err are low and every byte of the memory reads as zero.
- R2: A word store at an even address asserts both lane enables and stores req_wdata. A word load returns the 16-bit word on rd_data with rd_valid high in the cycle after the request.
- R3: A byte load returns on rd_data[7:0] the low lane (bits 7:0 of the word) when address bit 0 is 0, and the high lane (bits 15:8) when it is 1.
- R4: For a byte load, rd_data[15:8] equals the dst_hi value presented with the request.
- R5: A byte store asserts only wr_lo_en when address bit 0 is 0, and only wr_hi_en when it is 1. It writes req_wdata[7:0] into that lane and leaves the other lane unchanged.
- R6: A word access with address bit 0 set gives addr_err high for exactly the cycle after the request, with err_addr equal to the request address. Byte accesses never raise it.
- R7: A misaligned word load still completes: rd_valid is high and rd_data holds the word at the address with bit 0 cleared.
- R8: A misaligned word store asserts neither lane enable and leaves the memory unchanged.
- R9: ptr_next equals req_addr plus 1 for a byte access and plus 2 for a word access, modulo 2^16.
- R10: ext_mode 2'b01 gives ext_out = {8 copies of ext_in[7], ext_in[7:0]}. 2'b10 gives {8'h00, ext_in[7:0]}. 2'b00 and 2'b11 pass ext_in unchanged.
- R11: With the default depth of 512 words, the word index is req_addr[9:1]. Higher address bits are ignored, so addresses 0x0410 and 0x0010 name the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_byte | input | 1 | 1 = byte access, 0 = word access |
| req_addr | input | 16 | Effective byte address |
| req_wdata | input | 16 | Store data (a byte store uses bits 7:0) |
| dst_hi | input | 8 | Current high byte of the destination register |
| ptr_next | output | 16 | Post-incremented pointer for this access size |
| wr_lo_en | output | 1 | Low lane write strobe |
| wr_hi_en | output | 1 | High lane write strobe |
| rd_valid | output | 1 | Load result valid |
| rd_data | output | 16 | Merged load result for the destination register |
| addr_err | output | 1 | Address-error trap pulse |
| err_addr | output | 16 | Address of the last misaligned word access |
| ext_mode | input | 2 | Extend helper mode |
| ext_in | input | 16 | Extend helper operand |
| ext_out | output | 16 | Extend helper result |

## Verification
The assertions assume that req_write, req_byte, req_addr and dst_hi are stable for the whole cycle in which req_valid is high. They also assume req_valid is low during reset, so that the $past terms after reset see an idle cycle.

The bench changes inputs only on the falling edge and holds req_valid low while reset is active. It never issues two requests in the same cycle, because the port admits only one.

The vectors store before they load. Each load therefore has a known expected value, whether it reads a plain word, a byte lane, a misaligned word or an aliased address.

// File: rtl/dmau_pkg.sv
package dmau_pkg;

  typedef enum logic [1:0] {
    EXT_NONE  = 2'b00,
    EXT_SIGN  = 2'b01,
    EXT_ZERO  = 2'b10,
    EXT_NONE2 = 2'b11
  } ext_mode_e;

  // Pointer advance scaled by access size.
  function automatic logic [15:0] f_step(input logic [15:0] a, input logic is_byte);
    return a + (is_byte ? 16'd1 : 16'd2);
  endfunction

  // A word access at an odd byte address is an alignment fault.
  function automatic logic f_misaligned(input logic [15:0] a, input logic is_byte);
    return !is_byte && a[0];
  endfunction

  // Lane strobes {hi, lo} for a store.
  function automatic logic [1:0] f_lane_we(input logic [15:0] a, input logic is_byte);
    logic [1:0] we;
    if (is_byte)          we = a[0] ? 2'b10 : 2'b01;
    else if (a[0])        we = 2'b00;
    else                  we = 2'b11;
    return we;
  endfunction

  // Byte pick from a fetched word.
  function automatic logic [7:0] f_pick(input logic [15:0] w, input logic sel_hi);
    return sel_hi ? w[15:8] : w[7:0];
  endfunction

  function automatic logic [15:0] f_extend(input logic [15:0] v, input ext_mode_e m);
    logic [15:0] r;
    case (m)
      EXT_SIGN: r = {{8{v[7]}}, v[7:0]};
      EXT_ZERO: r = {8'h00, v[7:0]};
      default:  r = v;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/dmau_decode.sv
module dmau_decode
  import dmau_pkg::*;
#(
  parameter int DEPTH = 512,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_byte,
  input  logic [15:0]   req_addr,
  input  logic [15:0]   req_wdata,
  output logic [IW-1:0] word_idx,
  output logic [1:0]    lane_we,
  output logic [15:0]   lane_wd,
  output logic          misalign,
  output logic [15:0]   ptr_next
);

  logic store_fire;

  assign store_fire = req_valid && req_write;
  assign word_idx   = req_addr[IW:1];
  assign misalign   = req_valid && f_misaligned(req_addr, req_byte);
  assign ptr_next   = f_step(req_addr, req_byte);
  assign lane_we    = store_fire ? f_lane_we(req_addr, req_byte) : 2'b00;

  // A byte store replicates the byte on both lanes; only one strobe fires.
  assign lane_wd    = req_byte ? {req_wdata[7:0], req_wdata[7:0]} : req_wdata;

  AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_byte) |-> $onehot(lane_we)); // R5

  AST_MISALIGN_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !req_byte && req_addr[0]) |-> (lane_we == 2'b00)); // R8

  AST_WORD_BOTH_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !req_byte && !req_addr[0]) |-> (lane_we == 2'b11)); // R2

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ((ptr_next - req_addr) == (req_byte ? 16'd1 : 16'd2))); // R9

  AST_LOAD_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |-> (lane_we == 2'b00)); // R7

endmodule

// File: rtl/dmau_lanes.sv
module dmau_lanes #(
  parameter int DEPTH = 512,
  localparam int IW = $clog2(DEPTH),
  localparam int LANES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [IW-1:0] word_idx,
  input  logic [1:0]    lane_we,
  input  logic [15:0]   lane_wd,
  output logic [15:0]   rdata_q
);

  // Two byte-wide arrays that share one index and have separate strobes.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
        rdata_q[g*8 +: 8] <= 8'h00;
      end else begin
        if (lane_we[g]) mem[word_idx] <= lane_wd[g*8 +: 8];
        if (rd_en)      rdata_q[g*8 +: 8] <= mem[word_idx];
      end
    end
  end

endmodule

// File: rtl/dmau_merge.sv
module dmau_merge
  import dmau_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load_fire,
  input  logic        req_byte,
  input  logic        sel_hi,
  input  logic [7:0]  dst_hi,
  input  logic [15:0] rdata_q,
  output logic        rd_valid,
  output logic [15:0] rd_data
);

  logic       byte_q;
  logic       sel_q;
  logic [7:0] keep_q;
  logic [7:0] picked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      byte_q   <= 1'b0;
      sel_q    <= 1'b0;
      keep_q   <= 8'h00;
    end else begin
      rd_valid <= load_fire;
      if (load_fire) begin
        byte_q <= req_byte;
        sel_q  <= sel_hi;
        keep_q <= dst_hi;
      end
    end
  end

  assign picked  = f_pick(rdata_q, sel_q);
  assign rd_data = byte_q ? {keep_q, picked} : rdata_q;

endmodule

// File: rtl/dmem_access_unit.sv
module dmem_access_unit
  import dmau_pkg::*;
#(
  parameter int DEPTH = 512,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic        req_byte,
  input  logic [15:0] req_addr,
  input  logic [15:0] req_wdata,
  input  logic [7:0]  dst_hi,
  output logic [15:0] ptr_next,
  output logic        wr_lo_en,
  output logic        wr_hi_en,
  output logic        rd_valid,
  output logic [15:0] rd_data,
  output logic        addr_err,
  output logic [15:0] err_addr,
  input  logic [1:0]  ext_mode,
  input  logic [15:0] ext_in,
  output logic [15:0] ext_out
);

  logic [IW-1:0] word_idx;
  logic [1:0]    lane_we;
  logic [15:0]   lane_wd;
  logic          misalign;
  logic          load_fire;
  logic [15:0]   rdata_q;

  assign load_fire = req_valid && !req_write;

  dmau_decode #(.DEPTH(DEPTH)) u_decode (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_byte  (req_byte),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .word_idx  (word_idx),
    .lane_we   (lane_we),
    .lane_wd   (lane_wd),
    .misalign  (misalign),
    .ptr_next  (ptr_next)
  );

  dmau_lanes #(.DEPTH(DEPTH)) u_lanes (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (load_fire),
    .word_idx (word_idx),
    .lane_we  (lane_we),
    .lane_wd  (lane_wd),
    .rdata_q  (rdata_q)
  );

  dmau_merge u_merge (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_fire (load_fire),
    .req_byte  (req_byte),
    .sel_hi    (req_addr[0]),
    .dst_hi    (dst_hi),
    .rdata_q   (rdata_q),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );

  assign wr_lo_en = lane_we[0];
  assign wr_hi_en = lane_we[1];

  // The trap pulse and the faulting address are registered together.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_err <= 1'b0;
      err_addr <= 16'h0000;
    end else begin
      addr_err <= misalign;
      if (misalign) err_addr <= req_addr;
    end
  end

  assign ext_out = f_extend(ext_in, ext_mode_e'(ext_mode));

  AST_TRAP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err |-> $past(req_valid && !req_byte && req_addr[0])); // R6

  AST_TRAP_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err |-> (err_addr == $past(req_addr))); // R6

  AST_READ_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(req_valid && !req_write)); // R7

  AST_KEEP_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(req_byte)) |-> (rd_data[15:8] == $past(dst_hi))); // R4

  AST_SIGN_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_mode == 2'b01) |-> (ext_out[15:8] == {8{ext_in[7]}})); // R10

endmodule

// File: tb/sim_dmem_access_unit.sv
module sim_dmem_access_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_byte = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic [7:0]  dst_hi = '0;
  logic [15:0] ptr_next, rd_data, err_addr, ext_out;
  logic        wr_lo_en, wr_hi_en, rd_valid, addr_err;
  logic [1:0]  ext_mode = 2'b00;
  logic [15:0] ext_in = '0;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dmem_access_unit u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_byte(req_byte), .req_addr(req_addr), .req_wdata(req_wdata),
    .dst_hi(dst_hi), .ptr_next(ptr_next), .wr_lo_en(wr_lo_en),
    .wr_hi_en(wr_hi_en), .rd_valid(rd_valid), .rd_data(rd_data),
    .addr_err(addr_err), .err_addr(err_addr), .ext_mode(ext_mode),
    .ext_in(ext_in), .ext_out(ext_out)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Vector layout: wr, byte, addr, wdata, dst_hi, expected rd_data, expected err
  localparam int NV = 15;
  localparam logic [58:0] TBL [NV] = '{
    {1'b1, 1'b0, 16'h0010, 16'hA1B2, 8'h00, 16'h0000, 1'b0},
    {1'b0, 1'b0, 16'h0010, 16'h0000, 8'h00, 16'hA1B2, 1'b0},
    {1'b1, 1'b1, 16'h0013, 16'h55C3, 8'h00, 16'h0000, 1'b0},
    {1'b0, 1'b0, 16'h0012, 16'h0000, 8'h00, 16'hC300, 1'b0},
    {1'b0, 1'b1, 16'h0011, 16'h0000, 8'h7E, 16'h7EA1, 1'b0},
    {1'b0, 1'b1, 16'h0010, 16'h0000, 8'h12, 16'h12B2, 1'b0},
    {1'b1, 1'b1, 16'h0012, 16'h0044, 8'h00, 16'h0000, 1'b0},
    {1'b0, 1'b0, 16'h0012, 16'h0000, 8'h00, 16'hC344, 1'b0},
    {1'b1, 1'b0, 16'h0015, 16'hFFFF, 8'h00, 16'h0000, 1'b1},
    {1'b0, 1'b0, 16'h0014, 16'h0000, 8'h00, 16'h0000, 1'b0},
    {1'b0, 1'b0, 16'h0011, 16'h0000, 8'h00, 16'hA1B2, 1'b1},
    {1'b0, 1'b1, 16'h0013, 16'h0000, 8'hFF, 16'hFFC3, 1'b0},
    {1'b0, 1'b0, 16'h0410, 16'h0000, 8'h00, 16'hA1B2, 1'b0},
    {1'b1, 1'b0, 16'h0412, 16'hBEEF, 8'h00, 16'h0000, 1'b0},
    {1'b0, 1'b1, 16'h0013, 16'h0000, 8'h00, 16'h00BE, 1'b0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    chk("R1 rd_valid in reset", {15'd0, rd_valid}, 16'd0);
    chk("R1 addr_err in reset", {15'd0, addr_err}, 16'd0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic        wr, byt, e_err, e_lo, e_hi;
      logic [15:0] a, wd, e_rd;
      logic [7:0]  dh;
      {wr, byt, a, wd, dh, e_rd, e_err} = TBL[i];
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_byte = byt;
      req_addr = a; req_wdata = wd; dst_hi = dh;
      #1;
      e_lo = wr && !a[0];
      e_hi = wr && (byt ? a[0] : !a[0]);
      chk(byt ? "R5 wr_lo_en" : (a[0] ? "R8 wr_lo_en" : "R2 wr_lo_en"), {15'd0, wr_lo_en}, {15'd0, e_lo});
      chk(byt ? "R5 wr_hi_en" : (a[0] ? "R8 wr_hi_en" : "R2 wr_hi_en"), {15'd0, wr_hi_en}, {15'd0, e_hi});
      chk("R9 ptr_next", ptr_next, a + (byt ? 16'd1 : 16'd2));
      @(posedge clk);
      #1;
      chk("R2 rd_valid", {15'd0, rd_valid}, {15'd0, !wr});
      if (!wr)
        chk(byt ? "R3 R4 byte load" : (a[0] ? "R7 misaligned load" : "R2 R11 word load"), rd_data, e_rd);
      chk("R6 addr_err", {15'd0, addr_err}, {15'd0, e_err});
      if (e_err) chk("R6 err_addr", err_addr, a);
    end

    @(negedge clk);
    req_valid = 1'b0;
    @(posedge clk);
    #1;
    chk("R6 single-cycle pulse", {15'd0, addr_err}, 16'd0);

    // R10: extend helper
    ext_in = 16'h1280; ext_mode = 2'b01; #1; chk("R10 sign neg", ext_out, 16'hFF80);
    ext_in = 16'hAB7F; ext_mode = 2'b01; #1; chk("R10 sign pos", ext_out, 16'h007F);
    ext_in = 16'hAB99; ext_mode = 2'b10; #1; chk("R10 zero", ext_out, 16'h0099);
    ext_in = 16'h5A3C; ext_mode = 2'b00; #1; chk("R10 pass 00", ext_out, 16'h5A3C);
    ext_in = 16'hC3E1; ext_mode = 2'b11; #1; chk("R10 pass 11", ext_out, 16'hC3E1);

    // R1: reset clears the memory contents
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    req_valid = 1'b1; req_write = 1'b0; req_byte = 1'b0; req_addr = 16'h0010;
    @(posedge clk);
    #1;
    chk("R1 memory cleared", rd_data, 16'h0000);
    @(negedge clk);
    req_valid = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule